// File: doc/BRIEF.md
# Kernel Control and Argument Register Slave

This block sits between a host-facing AXI4-Lite bus and the core of a hardware kernel. The host launches the kernel through a control word, then watches that word, or a single interrupt line, to learn when the run has finished. The kernel core receives a one-cycle launch strobe and answers with a completion pulse. The block turns that pulse into the busy, idle and completion flags the host reads.

The block also holds the kernel's arguments: one 32-bit scalar and two 64-bit base addresses for the arrays the kernel walks. These values drive output ports that the core reads directly. Interrupt delivery uses one global gate, one enable per event source and a status register that clears when read. The datapath and the memory master are not part of this block.

Top module: `kern_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, except that the control word reads 0x4 (idle, bit 2, set). The irq, core_start, s_bvalid and s_rvalid outputs are low and all argument ports are zero.
- R2: A write with strobe lane 0 set and data bit 0 = 1 to offset 0x00 while idle launches a run. Control bit 0 (running) reads 1, bit 2 (idle) reads 0, and core_start is high for exactly one cycle.
- R3: While running, a further write of 1 to control bit 0 gives no new strobe, and a write of 0 does not stop the run.
- R4: A core_done pulse during a run clears the running bit, sets the idle bit and sets control bit 1 (completed), all at the same clock edge.
- R5: The completed bit is sticky. A read of offset 0x00 returns it set and clears it, so the next read of offset 0x00 returns 0x4.
- R6: A core_done pulse while idle is ignored. The control word stays 0x4 and the status register stays zero.
- R7: Status register 0x0C: bit 0 is set on completion and bit 1 on launch, whatever the enables hold. A read returns the pending bits and clears them. Writes to 0x0C have no effect.
- R8: irq equals global enable bit 0 (offset 0x04) AND the OR of (status AND per-source enable at offset 0x08, bits 1:0).
- R9: Argument map: scalar at 0x10; array A base low and high words at 0x18 and 0x1C; array B base low and high words at 0x24 and 0x28. Each word reads back and drives its output port.
- R10: Writes update only the byte lanes whose WSTRB bit is set.
- R11: Reads of unmapped offsets return zero, writes to them change nothing, and every response is OKAY (0).
- R12: Only one write response and one read response can be outstanding at a time. s_bvalid stays high until s_bready is high. s_rdata stays unchanged while s_rvalid is high and s_rready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 6 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 6 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| core_start | output | 1 | One-cycle launch strobe to the core |
| core_done | input | 1 | Completion pulse from the core |
| arg_scalar | output | 32 | Scalar argument |
| arg_a_base | output | 64 | Base address of array A |
| arg_b_base | output | 64 | Base address of array B |
| irq | output | 1 | Interrupt request |

## Verification
The launch and completion handshake is tested with the ordinary sequence and with the patterns it must reject. Those patterns are a repeated launch, a write of zero during a run and a completion pulse while idle. Together they separate a level-driven start from an edge-qualified one. The interrupt output is swept over every combination of global enable and per-source enable, in two cases: only the launch event pending, and both events pending. This exposes a missing gate or a swapped source bit. A sweep of all sixteen strobe patterns over one argument word shows whether each byte lane is steered on its own. A sweep over the unmapped offsets shows that they are decoded to nothing.

// File: rtl/kctl_pkg.sv
package kctl_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int STRB_W  = DATA_W / 8;
    localparam int WORD_W  = ADDR_W - 2;
    localparam int N_SRC   = 2;
    localparam int SRC_DONE   = 0;
    localparam int SRC_LAUNCH = 1;
    localparam int N_ARG   = 5;
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_CMPL = 1;
    localparam int CTRL_IDLE = 2;

    // word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_GIE    = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_IER    = WORD_W'(2);
    localparam logic [WORD_W-1:0] W_ISR    = WORD_W'(3);
    localparam logic [WORD_W-1:0] W_SCALAR = WORD_W'(4);
    localparam logic [WORD_W-1:0] W_A_LO   = WORD_W'(6);
    localparam logic [WORD_W-1:0] W_A_HI   = WORD_W'(7);
    localparam logic [WORD_W-1:0] W_B_LO   = WORD_W'(9);
    localparam logic [WORD_W-1:0] W_B_HI   = WORD_W'(10);

    localparam logic [1:0] RESP_OKAY = 2'b00;

    function automatic logic [WORD_W-1:0] arg_word(input int idx);
        case (idx)
            0:       return W_SCALAR;
            1:       return W_A_LO;
            2:       return W_A_HI;
            3:       return W_B_LO;
            default: return W_B_HI;
        endcase
    endfunction
endpackage

// File: rtl/kctl_axil_front.sv
module kctl_axil_front
    import kctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    output logic              rd_en,
    output logic [WORD_W-1:0] rd_idx,
    input  logic [DATA_W-1:0] rd_word
);
    typedef struct packed {
        logic              bvalid;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } front_t;

    front_t st_d, st_q;
    logic   unused_addr_lsb;

    assign wr_en   = awvalid & wvalid & ~st_q.bvalid;
    assign rd_en   = arvalid & ~st_q.rvalid;
    assign awready = wr_en;
    assign wready  = wr_en;
    assign arready = ~st_q.rvalid;
    assign wr_idx  = awaddr[ADDR_W-1:2];
    assign rd_idx  = araddr[ADDR_W-1:2];
    assign wr_data = wdata;
    assign wr_strb = wstrb;
    assign bvalid  = st_q.bvalid;
    assign rvalid  = st_q.rvalid;
    assign rdata   = st_q.rdata;
    assign unused_addr_lsb = ^{awaddr[1:0], araddr[1:0]};

    always_comb begin
        st_d = st_q;
        if (st_q.bvalid && bready) st_d.bvalid = 1'b0;
        if (wr_en)                 st_d.bvalid = 1'b1;
        if (st_q.rvalid && rready) st_d.rvalid = 1'b0;
        if (rd_en) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/kctl_handshake.sv
module kctl_handshake
    import kctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_idx,
    input  logic [N_SRC-1:0]  wr_bits,
    input  logic              wr_lane0,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] rd_idx,
    input  logic              core_done,
    output logic              core_start,
    output logic              busy,
    output logic              cmpl,
    output logic              gie,
    output logic [N_SRC-1:0]  ier,
    output logic [N_SRC-1:0]  isr,
    output logic              irq
);
    typedef struct packed {
        logic             run;
        logic             strobe;
        logic             cmpl;
        logic             gie;
        logic [N_SRC-1:0] ier;
        logic [N_SRC-1:0] isr;
    } hs_t;

    hs_t              st_d, st_q;
    logic             hit_ctrl, launch, finish;
    logic [N_SRC-1:0] events;

    assign hit_ctrl = wr_en && wr_lane0 && (wr_idx == W_CTRL);
    assign launch   = hit_ctrl && wr_bits[0] && !st_q.run;
    assign finish   = core_done && st_q.run;

    always_comb begin
        events             = '0;
        events[SRC_DONE]   = finish;
        events[SRC_LAUNCH] = launch;
    end

    always_comb begin
        st_d        = st_q;
        st_d.strobe = launch;
        if (finish)      st_d.run = 1'b0;
        else if (launch) st_d.run = 1'b1;
        if (rd_en && rd_idx == W_CTRL) st_d.cmpl = 1'b0;
        if (finish)                    st_d.cmpl = 1'b1;
        if (wr_en && wr_lane0 && wr_idx == W_GIE) st_d.gie = wr_bits[0];
        if (wr_en && wr_lane0 && wr_idx == W_IER) st_d.ier = wr_bits;
        st_d.isr = ((rd_en && rd_idx == W_ISR) ? '0 : st_q.isr) | events;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign core_start = st_q.strobe;
    assign busy       = st_q.run;
    assign cmpl       = st_q.cmpl;
    assign gie        = st_q.gie;
    assign ier        = st_q.ier;
    assign isr        = st_q.isr;
    assign irq        = st_q.gie & (|(st_q.isr & st_q.ier));
endmodule

// File: rtl/kctl_arg_bank.sv
module kctl_arg_bank
    import kctl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [WORD_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [STRB_W-1:0]            wr_strb,
    output logic [N_ARG-1:0][DATA_W-1:0] words
);
    typedef struct packed {
        logic [N_ARG-1:0][DATA_W-1:0] w;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int a = 0; a < N_ARG; a++) begin
            for (int b = 0; b < STRB_W; b++) begin
                if (wr_en && wr_strb[b] && wr_idx == arg_word(a))
                    st_d.w[a][b*8 +: 8] = wr_data[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words = st_q.w;
endmodule

// File: rtl/kern_ctrl_regs.sv
module kern_ctrl_regs
    import kctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              core_start,
    input  logic              core_done,
    output logic [DATA_W-1:0] arg_scalar,
    output logic [2*DATA_W-1:0] arg_a_base,
    output logic [2*DATA_W-1:0] arg_b_base,
    output logic              irq
);
    logic                         wr_en, rd_en;
    logic [WORD_W-1:0]            wr_idx, rd_idx;
    logic [DATA_W-1:0]            wr_data, rd_word;
    logic [STRB_W-1:0]            wr_strb;
    logic                         hs_busy, hs_cmpl, hs_gie;
    logic [N_SRC-1:0]             hs_ier, hs_isr;
    logic [N_ARG-1:0][DATA_W-1:0] arg_words;

    kctl_axil_front u_front (
        .clk(clk), .rst_n(rst_n),
        .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
        .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
        .bvalid(s_bvalid), .bready(s_bready),
        .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
        .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    kctl_handshake u_hs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bits(wr_data[N_SRC-1:0]),
        .wr_lane0(wr_strb[0]),
        .rd_en(rd_en), .rd_idx(rd_idx),
        .core_done(core_done), .core_start(core_start),
        .busy(hs_busy), .cmpl(hs_cmpl), .gie(hs_gie),
        .ier(hs_ier), .isr(hs_isr), .irq(irq)
    );

    kctl_arg_bank u_args (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
        .words(arg_words)
    );

    always_comb begin
        rd_word = '0;
        unique case (rd_idx)
            W_CTRL: begin
                rd_word[CTRL_RUN]  = hs_busy;
                rd_word[CTRL_CMPL] = hs_cmpl;
                rd_word[CTRL_IDLE] = ~hs_busy;
            end
            W_GIE:   rd_word[0]         = hs_gie;
            W_IER:   rd_word[N_SRC-1:0] = hs_ier;
            W_ISR:   rd_word[N_SRC-1:0] = hs_isr;
            default: begin
                for (int a = 0; a < N_ARG; a++)
                    if (rd_idx == arg_word(a)) rd_word = arg_words[a];
            end
        endcase
    end

    assign s_bresp    = RESP_OKAY;
    assign s_rresp    = RESP_OKAY;
    assign arg_scalar = arg_words[0];
    assign arg_a_base = {arg_words[2], arg_words[1]};
    assign arg_b_base = {arg_words[4], arg_words[3]};
endmodule

// File: rtl/kctl_chk.sv
module kctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        core_start,
    input logic        core_done,
    input logic        busy,
    input logic        gie_on,
    input logic        irq,
    input logic        s_awready,
    input logic        s_bvalid,
    input logic        s_bready,
    input logic        s_rvalid,
    input logic        s_rready,
    input logic [31:0] s_rdata
);
    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);
    // R2
    busy_needs_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> core_start);
    // R4
    done_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && core_done) |=> !busy);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_on |-> !irq);
    // R12
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);
    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
    // R12
    single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !s_awready);
endmodule

bind kern_ctrl_regs kctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_done(core_done),
    .busy(hs_busy), .gie_on(hs_gie), .irq(irq), .s_awready(s_awready),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_rvalid(s_rvalid),
    .s_rready(s_rready), .s_rdata(s_rdata)
);

// File: tb/kern_ctrl_regs_bench.sv
`timescale 1ns/1ps
module kern_ctrl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
    logic [5:0]  s_awaddr = 0, s_araddr = 0;
    logic [31:0] s_wdata = 0;
    logic [3:0]  s_wstrb = 0;
    logic        core_done = 0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid, core_start, irq;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata, arg_scalar;
    logic [63:0] arg_a_base, arg_b_base;

    int checks = 0, errors = 0, pulses = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    kern_ctrl_regs u_kern_ctrl_regs (.*);

    always @(posedge clk) if (rst_n && core_start) pulses <= pulses + 1;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        s_awvalid = 1; s_wvalid = 1; s_awaddr = a; s_wdata = d; s_wstrb = s;
        while (!s_awready) @(negedge clk);
        @(posedge clk); #1;
        s_awvalid = 0; s_wvalid = 0;
        @(negedge clk);
        chk("R11 bresp", {62'd0, s_bresp}, 64'd0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        s_arvalid = 1; s_araddr = a;
        while (!s_arready) @(negedge clk);
        @(posedge clk); #1;
        s_arvalid = 0;
        @(negedge clk);
        d = s_rdata;
        chk("R11 rresp", {62'd0, s_rresp}, 64'd0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk); core_done = 1;
        @(negedge clk); core_done = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pat, exp;
        logic [63:0] sa, sb;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {63'd0, irq}, 0);
        chk("R1 core_start", {63'd0, core_start}, 0);
        chk("R1 bvalid/rvalid", {62'd0, s_bvalid, s_rvalid}, 0);
        chk("R1 args", arg_scalar | arg_a_base | arg_b_base, 0);
        rd(6'h00, rv); chk("R1 ctrl", rv, 32'h4);
        rd(6'h0C, rv); chk("R1 isr", rv, 0);

        // R9 argument map
        wr(6'h10, 32'h1234_5678, 4'hF);
        wr(6'h18, 32'hA0A1_A2A3, 4'hF);
        wr(6'h1C, 32'hA4A5_A6A7, 4'hF);
        wr(6'h24, 32'hB0B1_B2B3, 4'hF);
        wr(6'h28, 32'hB4B5_B6B7, 4'hF);
        chk("R9 scalar port", arg_scalar, 32'h1234_5678);
        chk("R9 A port", arg_a_base, 64'hA4A5_A6A7_A0A1_A2A3);
        chk("R9 B port", arg_b_base, 64'hB4B5_B6B7_B0B1_B2B3);
        rd(6'h1C, rv); chk("R9 A hi read", rv, 32'hA4A5_A6A7);
        rd(6'h24, rv); chk("R9 B lo read", rv, 32'hB0B1_B2B3);

        // R10 strobe sweep
        pat = 32'hA5C3_1E7B;
        for (int s = 0; s < 16; s++) begin
            wr(6'h10, 32'h0, 4'hF);
            wr(6'h10, pat, 4'(s));
            exp = 0;
            for (int b = 0; b < 4; b++) if (s[b]) exp[b*8 +: 8] = pat[b*8 +: 8];
            chk("R10 strobe port", arg_scalar, exp);
            rd(6'h10, rv); chk("R10 strobe read", rv, exp);
        end

        // R11 unmapped offsets
        sa = arg_a_base; sb = arg_b_base;
        for (int o = 0; o < 16; o++) begin
            if (o == 5 || o == 8 || o >= 11) begin
                wr(6'(o*4), 32'hFFFF_FFFF, 4'hF);
                rd(6'(o*4), rv); chk("R11 unmapped read", rv, 0);
            end
        end
        chk("R11 A unchanged", arg_a_base, sa);
        chk("R11 B unchanged", arg_b_base, sb);
        chk("R11 scalar unchanged", arg_scalar, exp);
        chk("R11 no launch", pulses, 0);

        // R2 launch
        wr(6'h00, 32'h1, 4'h1);
        chk("R2 one strobe", pulses, 1);
        rd(6'h00, rv); chk("R2 ctrl running", rv, 32'h1);
        // R3 relaunch and clear ignored
        wr(6'h00, 32'h1, 4'h1);
        chk("R3 no second strobe", pulses, 1);
        wr(6'h00, 32'h0, 4'hF);
        rd(6'h00, rv); chk("R3 still running", rv, 32'h1);
        // R4 / R5 completion
        done_pulse();
        rd(6'h00, rv); chk("R4 ctrl after done", rv, 32'h6);
        rd(6'h00, rv); chk("R5 completed cleared", rv, 32'h4);
        // R7 status
        rd(6'h0C, rv); chk("R7 isr both", rv, 32'h3);
        rd(6'h0C, rv); chk("R7 isr cleared", rv, 32'h0);
        wr(6'h00, 32'h1, 4'h1);
        wr(6'h0C, 32'hFFFF_FFFF, 4'hF);
        rd(6'h0C, rv); chk("R7 write ignored", rv, 32'h2);
        done_pulse();
        rd(6'h00, rv);
        rd(6'h0C, rv); chk("R7 done bit", rv, 32'h1);
        // R6 stray done
        done_pulse();
        rd(6'h00, rv); chk("R6 ctrl idle", rv, 32'h4);
        rd(6'h0C, rv); chk("R6 isr empty", rv, 32'h0);

        // R8 interrupt sweep
        pulses = 0;
        for (int g = 0; g < 2; g++) begin
            for (int e = 0; e < 4; e++) begin
                wr(6'h08, 32'(e), 4'hF);
                wr(6'h04, 32'(g), 4'hF);
                wr(6'h00, 32'h1, 4'h1);
                chk("R8 irq launch only", {63'd0, irq}, 64'(g & e[1]));
                done_pulse();
                chk("R8 irq both", {63'd0, irq}, 64'(g & (e[0] | e[1])));
                rd(6'h0C, rv); chk("R7 isr read", rv, 32'h3);
                chk("R8 irq after clear", {63'd0, irq}, 0);
                rd(6'h00, rv);
            end
        end
        chk("R2 strobe count", pulses, 8);

        // R12 held response channels
        wr(6'h04, 32'h0, 4'hF);
        s_bready = 0;
        @(negedge clk);
        s_awvalid = 1; s_wvalid = 1; s_awaddr = 6'h04; s_wdata = 0; s_wstrb = 4'hF;
        @(posedge clk); #1;
        s_awvalid = 0; s_wvalid = 0;
        repeat (3) begin
            @(negedge clk);
            chk("R12 bvalid held", {63'd0, s_bvalid}, 1);
        end
        s_bready = 1;
        @(posedge clk); @(negedge clk);
        chk("R12 bvalid released", {63'd0, s_bvalid}, 0);
        s_rready = 0;
        s_arvalid = 1; s_araddr = 6'h18;
        @(posedge clk); #1;
        s_arvalid = 0;
        repeat (3) begin
            @(negedge clk);
            chk("R12 rvalid held", {63'd0, s_rvalid}, 1);
            chk("R12 rdata stable", s_rdata, 32'hA0A1_A2A3);
        end
        s_rready = 1;
        @(posedge clk); @(negedge clk);
        chk("R12 rvalid released", {63'd0, s_rvalid}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule